// File: doc/BRIEF.md
# Accumulator CPU Core with Hardwired Control

This block is a small 8-bit processor built around one accumulator and a fixed state machine. It runs programs held in a 64-word, 8-bit external memory. The same memory holds both instructions and operands. Each instruction word puts a 2-bit opcode in bits [7:6] and a 6-bit direct address in bits [5:0]. The four operations are add-to-accumulator, and-with-accumulator, jump, and decrement-accumulator.

The core drives a 6-bit address and a read strobe. The memory answers on the read-data input. It is synchronous with one cycle of latency: a word requested with the strobe high at one clock edge is on the read-data input during the next cycle. The accumulator is driven to an output port at all times so that a display can show it.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is high, the accumulator output is 0x00 and the read strobe is low. The address output reads 0 at the first clock edge. After reset is released, the first instruction comes from address 0.
- R2: Each instruction starts with three fetch cycles. The address register takes the program counter. Next, the strobe is high with the program counter on the address output, and the program counter increments. Last, the returned word is decoded, and the strobe is low in that cycle.
- R3: Opcode 00 (ADD) sets the accumulator to the accumulator plus the memory word at the direct address, modulo 256.
- R4: Opcode 01 (AND) sets the accumulator to the bitwise AND of the accumulator and the memory word at the direct address.
- R5: Opcode 10 (JMP) leaves the accumulator unchanged. The next instruction is fetched from the direct address.
- R6: Opcode 11 (DEC) subtracts one from the accumulator, so 0x00 becomes 0xFF. Bits [5:0] of the instruction have no effect.
- R7: The program counter wraps from 63 to 0, so the instruction after the one at address 63 is fetched from address 0.
- R8: ADD and AND take five cycles in total. In the fourth cycle the strobe is high with the direct address on the address output. JMP and DEC take four cycles.
- R9: The read strobe is never high in two cycles in a row. The accumulator changes only at the end of the last cycle of ADD, AND or DEC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W (6) | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; the word is returned in the following cycle |
| mem_rdata | input | DATA_W (8) | Word returned by the memory |
| acc_out | output | DATA_W (8) | Accumulator value, for display |

## Verification
The bench builds the core with its default widths: a 6-bit address, an 8-bit word and the decrement done by the shared adder. With these values every address in the memory can be reached. This lets the bench place code in the last two words and watch the program counter wrap to zero. The 8-bit word lets addition carry out of the top bit and lets decrement wrap from zero to 0xFF. The bench models the memory and an instruction-level reference of the program counter and the accumulator. It checks the strobe, the address and the accumulator in every cycle of each instruction.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 2;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_AND = 2'b01,
      OP_JMP = 2'b10,
      OP_DEC = 2'b11
   } opcode_e;

   typedef enum logic [2:0] {
      S_FADDR,
      S_FREAD,
      S_FDEC,
      S_XREAD,
      S_XALU,
      S_XJMP,
      S_XDEC
   } state_e;

   typedef enum logic [1:0] {
      ALU_ADD,
      ALU_AND,
      ALU_DEC,
      ALU_PASS
   } alu_op_e;

   typedef struct packed {
      logic    ar_from_pc;
      logic    ar_from_mem;
      logic    pc_inc;
      logic    pc_load;
      logic    dr_load;
      logic    acc_load;
      alu_op_e alu_op;
      logic    mem_rd;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit DEC_VIA_ADDER = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] add_b;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] dec_y;

   generate
      if (DEC_VIA_ADDER) begin : g_shared_adder
         // decrement reuses the adder with an all-ones operand
         assign add_b = (op == ALU_DEC) ? {DATA_W{1'b1}} : b;
         assign sum   = a + add_b;
         assign dec_y = sum;
      end else begin : g_own_decrementer
         assign add_b = b;
         assign sum   = a + add_b;
         assign dec_y = a - {{(DATA_W-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD: y = sum;
         ALU_AND: y = a & b;
         ALU_DEC: y = dec_y;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  opcode_e fetched_opc,
   output state_e  state,
   output opcode_e ir,
   output ctrl_t   ctl
);

   state_e state_nx;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_FADDR;
         ir    <= OP_ADD;
      end else begin
         state <= state_nx;
         if (state == S_FDEC) ir <= fetched_opc;
      end
   end

   always_comb begin
      state_nx = S_FADDR;
      unique case (state)
         S_FADDR: state_nx = S_FREAD;
         S_FREAD: state_nx = S_FDEC;
         S_FDEC: begin
            unique case (fetched_opc)
               OP_ADD, OP_AND: state_nx = S_XREAD;
               OP_JMP:         state_nx = S_XJMP;
               default:        state_nx = S_XDEC;
            endcase
         end
         S_XREAD: state_nx = S_XALU;
         default: state_nx = S_FADDR;
      endcase
   end

   always_comb begin
      ctl        = '0;
      ctl.alu_op = ALU_PASS;
      unique case (state)
         S_FADDR: ctl.ar_from_pc = 1'b1;
         S_FREAD: begin
            ctl.mem_rd = 1'b1;
            ctl.pc_inc = 1'b1;
         end
         S_FDEC: begin
            ctl.dr_load     = 1'b1;
            ctl.ar_from_mem = 1'b1;
         end
         S_XREAD: ctl.mem_rd = 1'b1;
         S_XALU: begin
            ctl.dr_load  = 1'b1;
            ctl.acc_load = 1'b1;
            ctl.alu_op   = (ir == OP_ADD) ? ALU_ADD : ALU_AND;
         end
         S_XJMP: ctl.pc_load = 1'b1;
         default: begin
            ctl.acc_load = 1'b1;
            ctl.alu_op   = ALU_DEC;
         end
      endcase
   end

   // R8: an operand execute cycle is always preceded by its read cycle
   assert_exec_order_R8: assert property (@(posedge clk) disable iff (rst)
      (state == S_XALU) |-> ($past(state) == S_XREAD));

   // R2: the decode cycle follows the strobed fetch cycle
   assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
      (state == S_FDEC) |-> ($past(state) == S_FREAD));

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int DATA_W        = 8,
   parameter bit DEC_VIA_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  ctrl_t             ctl,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] ar,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] dr,
   output logic [DATA_W-1:0] acc
);

   logic [DATA_W-1:0] alu_y;

   acc_cpu_alu #(
      .DATA_W        (DATA_W),
      .DEC_VIA_ADDER (DEC_VIA_ADDER)
   ) u_alu (
      .op (ctl.alu_op),
      .a  (acc),
      .b  (mem_rdata),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ar  <= '0;
         pc  <= '0;
         dr  <= '0;
         acc <= '0;
      end else begin
         if (ctl.ar_from_pc)       ar <= pc;
         else if (ctl.ar_from_mem) ar <= mem_rdata[ADDR_W-1:0];
         if (ctl.pc_load)          pc <= ar;
         else if (ctl.pc_inc)      pc <= pc + 1'b1;
         if (ctl.dr_load)          dr <= mem_rdata;
         if (ctl.acc_load)         acc <= alu_y;
      end
   end

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      ctl.pc_inc |=> (pc == ADDR_W'($past(pc) + 1'b1)));

   assert_pc_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl.pc_inc && (pc == {ADDR_W{1'b1}})) |=> (pc == '0));

   assert_jmp_target_R5: assert property (@(posedge clk) disable iff (rst)
      ctl.pc_load |=> (pc == $past(ar)));

   assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !ctl.acc_load |=> $stable(acc));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int DATA_W        = 8,
   parameter bit DEC_VIA_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_out
);

   localparam int WORD_W = OPC_W + ADDR_W;

   generate
      if (DATA_W != WORD_W) begin : g_bad_word
         $error("acc_cpu_core: DATA_W must equal opcode width plus ADDR_W");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("acc_cpu_core: ADDR_W must be at least 1");
      end
   endgenerate

   state_e            state;
   opcode_e           ir;
   ctrl_t             ctl;
   logic [ADDR_W-1:0] ar;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] dr;
   logic [DATA_W-1:0] acc;
   opcode_e           fetched_opc;

   assign fetched_opc = opcode_e'(mem_rdata[DATA_W-1 -: OPC_W]);

   acc_cpu_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .fetched_opc (fetched_opc),
      .state       (state),
      .ir          (ir),
      .ctl         (ctl)
   );

   acc_cpu_datapath #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .DEC_VIA_ADDER (DEC_VIA_ADDER)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .ar        (ar),
      .pc        (pc),
      .dr        (dr),
      .acc       (acc)
   );

   assign mem_addr = ar;
   assign mem_rd   = ctl.mem_rd;
   assign acc_out  = acc;

   assert_add_R3: assert property (@(posedge clk) disable iff (rst)
      (state == S_XALU && ir == OP_ADD) |=>
         (acc == DATA_W'($past(acc) + $past(mem_rdata))));

   assert_and_R4: assert property (@(posedge clk) disable iff (rst)
      (state == S_XALU && ir == OP_AND) |=>
         (acc == ($past(acc) & $past(mem_rdata))));

   assert_dec_R6: assert property (@(posedge clk) disable iff (rst)
      (state == S_XDEC) |=> (acc == DATA_W'($past(acc) - 1'b1)));

   assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd);

   assert_operand_latch_R8: assert property (@(posedge clk) disable iff (rst)
      (state == S_XALU) |=> (dr == $past(mem_rdata)));

endmodule

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;

   localparam real CLK_PERIOD = 20.0;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] mem_addr;
   logic       mem_rd;
   logic [7:0] mem_rdata = 8'h00;
   logic [7:0] acc_out;

   logic [7:0] mem [0:63];
   logic [5:0] ref_pc;
   logic [7:0] ref_acc;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu_core u0 (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_rdata (mem_rdata),
      .acc_out   (acc_out)
   );

   // synchronous memory, one cycle of read latency
   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
   endtask

   // R1: hold reset, check outputs, release at a falling edge
   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 acc during reset", acc_out, 8'h00);
      chk("R1 strobe during reset", mem_rd, 1'b0);
      chk("R1 address during reset", mem_addr, 6'd0);
      rst = 1'b0;
      ref_pc  = 6'd0;
      ref_acc = 8'h00;
   endtask

   // runs one instruction from the first fetch cycle to the next one
   task automatic run_instr(input string tag);
      logic [7:0] w;
      logic [5:0] a;
      logic [7:0] exp_acc;
      w = mem[ref_pc];
      a = w[5:0];
      @(negedge clk);
      chk("R2 fetch strobe", mem_rd, 1'b1);
      chk("R2/R5/R7 fetch address", mem_addr, ref_pc);
      ref_pc = ref_pc + 6'd1;
      @(negedge clk);
      chk("R2 no strobe in decode", mem_rd, 1'b0);
      case (w[7:6])
         2'b00, 2'b01: begin
            exp_acc = (w[7:6] == 2'b00) ? ref_acc + mem[a] : ref_acc & mem[a];
            @(negedge clk);
            chk("R8 operand strobe", mem_rd, 1'b1);
            chk("R8 operand address", mem_addr, a);
            @(negedge clk);
            chk("R9 acc held before execute", acc_out, ref_acc);
            @(negedge clk);
            ref_acc = exp_acc;
            chk(tag, acc_out, ref_acc);
         end
         2'b10: begin
            @(negedge clk);
            @(negedge clk);
            ref_pc = a;
            chk("R5 jump keeps acc", acc_out, ref_acc);
         end
         default: begin
            @(negedge clk);
            @(negedge clk);
            ref_acc = ref_acc - 8'd1;
            chk(tag, acc_out, ref_acc);
         end
      endcase
   endtask

   task automatic test_reset();
      clear_mem();
      mem[0] = 8'h80;            // JMP 0
      do_reset();
      chk("R1 acc after release", acc_out, 8'h00);
      run_instr("R1");
      run_instr("R1");
   endtask

   task automatic test_add();
      clear_mem();
      mem[0]  = 8'h28;           // ADD 40
      mem[1]  = 8'h29;           // ADD 41
      mem[2]  = 8'h82;           // JMP 2
      mem[40] = 8'hF0;
      mem[41] = 8'h25;           // carries out: 0x15
      do_reset();
      run_instr("R3 add");
      run_instr("R3 add modulo 256");
      run_instr("R5");
      chk("R3 final acc", acc_out, 8'h15);
   endtask

   task automatic test_and();
      clear_mem();
      mem[0]  = 8'hC0;           // DEC -> FF
      mem[1]  = 8'h68;           // AND 40
      mem[2]  = 8'h69;           // AND 41
      mem[3]  = 8'h83;
      mem[40] = 8'h3C;
      mem[41] = 8'hA5;
      do_reset();
      run_instr("R6 dec from zero");
      run_instr("R4 and");
      run_instr("R4 and second");
      chk("R4 final acc", acc_out, 8'h24);
   endtask

   task automatic test_dec();
      clear_mem();
      mem[0] = 8'hC0;
      mem[1] = 8'hFF;            // low bits all set
      mem[2] = 8'hD5;            // low bits mixed
      mem[3] = 8'h80;
      do_reset();
      run_instr("R6 dec 00 to FF");
      run_instr("R6 dec ignores low bits");
      run_instr("R6 dec ignores low bits again");
      chk("R6 final acc", acc_out, 8'hFD);
   endtask

   task automatic test_jmp_wrap();
      clear_mem();
      mem[0]  = 8'hBE;           // JMP 62
      mem[62] = 8'h32;           // ADD 50
      mem[63] = 8'hC0;           // DEC, then wrap to 0
      mem[50] = 8'h07;
      do_reset();
      for (int i = 0; i < 7; i++) run_instr("R7 wrap program");
      chk("R7 acc after two loops", acc_out, 8'h0C);
   endtask

   task automatic test_code_as_data();
      clear_mem();
      mem[0] = 8'h01;            // ADD M[1]
      mem[1] = 8'h00;            // ADD M[0]
      mem[2] = 8'h80;            // JMP 0
      do_reset();
      for (int i = 0; i < 4; i++) run_instr("R3 shared memory");
      chk("R3 acc reads code words", acc_out, 8'h01);
   endtask

   initial begin
      clear_mem();
      test_reset();
      test_add();
      test_and();
      test_dec();
      test_jmp_wrap();
      test_code_as_data();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule